// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides the peripheral clock into time quanta and arranges those quanta into the three segments of one CAN bit. The first segment is a synchronisation segment. The second is phase segment one and the third is phase segment two. For each quantum the block gives a one-cycle tick. It also gives a pulse when a bit begins, a strobe at the sample point and a code for the current segment. A protocol engine uses these signals to decide when to drive the bus and when to sample it.

Three settings control the timing: a prescaler code, a phase-one code and a phase-two code. Each phase code holds the segment length minus one. The settings are captured only while `enable` is low and are frozen while it is high. A legality check rejects setting combinations that cannot work. While a captured combination is illegal, the block raises `cfg_err`, holds its counters in reset and issues no pulses.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2 x (`prescale` + 1) clock cycles. `tq_tick` is high for exactly one cycle at the end of each quantum.
- R2: One bit lasts (3 + `seg1_len` + `seg2_len`) quanta. It is made of 1 sync quantum, then `seg1_len`+1 phase-one quanta, then `seg2_len`+1 phase-two quanta. The next bit follows with no gap.
- R3: A captured `seg1_len` code below 3 sets `cfg_err`. A `seg2_len` code of 0 also sets `cfg_err`.
- R4: A `seg2_len` code from 2 to 7 is legal only when the `seg1_len` code is numerically greater than it. Otherwise `cfg_err` is set.
- R5: A `seg2_len` code of 1 is legal only when the `seg1_len` code is 4 or more and `prescale` is non-zero.
- R6: While `cfg_err` is high, `tq_tick`, `bit_start` and `sample_pt` stay low and `segment` stays 0, even with `enable` high.
- R7: `sample_pt` is high for one cycle, together with the tick that ends the last phase-one quantum. Starting with the next cycle, `segment` is 2.
- R8: The settings are captured on each clock edge at which `enable` is low. Changes to them while `enable` is high have no effect on timing or on `cfg_err`.
- R9: Timing starts when `enable` is first sampled high at a clock edge, and the prescaler count starts from zero. The first tick, which is also the first `bit_start`, is visible after 2 x (`prescale`+1) - 1 such edges.
- R10: `segment` encodes sync, phase one and phase two as 0, 1 and 2. `bit_start` is high only together with a tick while `segment` is 0.
- R11: With `prescale`=0, `seg1_len`=4 and `seg2_len`=3, the interval between successive `bit_start` pulses is exactly 20 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the timing when high. Settings are captured while it is low |
| prescale | input | 6 | Prescaler code. The quantum is 2 x (code+1) clocks |
| seg1_len | input | 4 | Phase-one length minus one, in quanta |
| seg2_len | input | 3 | Phase-two length minus one, in quanta |
| tq_tick | output | 1 | One-cycle pulse at the end of each quantum |
| bit_start | output | 1 | One-cycle pulse on the tick that ends the sync quantum |
| sample_pt | output | 1 | One-cycle strobe at the boundary between phase one and phase two |
| segment | output | 2 | Current segment: 0 sync, 1 phase one, 2 phase two |
| cfg_err | output | 1 | High while the captured settings are illegal |

## Verification
The assertions check the local relations on every cycle:
- `bit_start` and `sample_pt` always fall on a tick, in the right segment.
- `segment` never takes the unused code.
- No pulse appears while `cfg_err` is high.
- `segment` moves to phase two right after the sample strobe.
- `cfg_err` cannot change while `enable` stays high.

Only the bench scenarios can show the durations and the rules for capturing settings:
- the quantum and bit lengths for several settings,
- the delay from enable to the first bit,
- the full legality matrix,
- the 20-cycle reference bit,
- that setting changes made during a run are ignored.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

    localparam int SEG1_MIN_CODE       = 3;
    localparam int SEG1_MIN_SHORT_CODE = 4;
    localparam int SEG2_SHORT_CODE     = 1;
endpackage

// File: rtl/cbt_legal.sv
module cbt_legal #(
    parameter int PRE_W = 6,
    parameter int T1_W  = 4,
    parameter int T2_W  = 3
) (
    input  logic [PRE_W-1:0] pre,
    input  logic [T1_W-1:0]  t1,
    input  logic [T2_W-1:0]  t2,
    output logic             bad
);
    import cbt_pkg::*;

    always_comb begin
        bad = 1'b0;
        if (int'(t1) < SEG1_MIN_CODE) begin
            bad = 1'b1;
        end else if (t2 == '0) begin
            bad = 1'b1;
        end else if (int'(t2) == SEG2_SHORT_CODE) begin
            bad = (int'(t1) < SEG1_MIN_SHORT_CODE) || (pre == '0);
        end else begin
            bad = !(int'(t1) > int'(t2));
        end
    end
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    localparam int CNT_W = PRE_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = {pre, 1'b1};
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == last) begin
            st_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cbt_segseq.sv
module cbt_segseq #(
    parameter int T1_W = 4,
    parameter int T2_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic [T1_W-1:0] t1,
    input  logic [T2_W-1:0] t2,
    output logic            bit_start,
    output logic            sample_pt,
    output logic [1:0]      seg
);
    import cbt_pkg::*;

    localparam int QW = (T1_W > T2_W) ? T1_W : T2_W;

    typedef struct packed {
        seg_e          seg;
        logic [QW-1:0] q;
    } seq_st_t;

    seq_st_t       st_d, st_q;
    logic [QW-1:0] t1_x, t2_x;

    always_comb begin
        t1_x      = QW'(t1);
        t2_x      = QW'(t2);
        st_d      = st_q;
        bit_start = 1'b0;
        sample_pt = 1'b0;
        if (!run) begin
            st_d.seg = SEG_SYNC;
            st_d.q   = '0;
        end else if (tick) begin
            unique case (st_q.seg)
                SEG_SYNC: begin
                    bit_start = 1'b1;
                    st_d.seg  = SEG_PH1;
                    st_d.q    = '0;
                end
                SEG_PH1: begin
                    if (st_q.q == t1_x) begin
                        sample_pt = 1'b1;
                        st_d.seg  = SEG_PH2;
                        st_d.q    = '0;
                    end else begin
                        st_d.q = st_q.q + 1'b1;
                    end
                end
                SEG_PH2: begin
                    if (st_q.q == t2_x) begin
                        st_d.seg = SEG_SYNC;
                        st_d.q   = '0;
                    end else begin
                        st_d.q = st_q.q + 1'b1;
                    end
                end
                default: begin
                    st_d.seg = SEG_SYNC;
                    st_d.q   = '0;
                end
            endcase
        end
        seg = st_q.seg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seg <= SEG_SYNC;
            st_q.q   <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int PRE_W = 6,
    parameter int T1_W  = 4,
    parameter int T2_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] prescale,
    input  logic [T1_W-1:0]  seg1_len,
    input  logic [T2_W-1:0]  seg2_len,
    output logic             tq_tick,
    output logic             bit_start,
    output logic             sample_pt,
    output logic [1:0]       segment,
    output logic             cfg_err
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [T1_W-1:0]  t1;
        logic [T2_W-1:0]  t2;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic bad;
    logic run;
    logic tick_int;

    always_comb begin
        cfg_d = cfg_q;
        if (!enable) begin
            cfg_d.pre = prescale;
            cfg_d.t1  = seg1_len;
            cfg_d.t2  = seg2_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    cbt_legal #(.PRE_W(PRE_W), .T1_W(T1_W), .T2_W(T2_W)) u_legal (
        .pre (cfg_q.pre),
        .t1  (cfg_q.t1),
        .t2  (cfg_q.t2),
        .bad (bad)
    );

    assign run = enable && !bad;

    cbt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .pre   (cfg_q.pre),
        .tick  (tick_int)
    );

    cbt_segseq #(.T1_W(T1_W), .T2_W(T2_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick_int),
        .t1        (cfg_q.t1),
        .t2        (cfg_q.t2),
        .bit_start (bit_start),
        .sample_pt (sample_pt),
        .seg       (segment)
    );

    assign tq_tick = tick_int;
    assign cfg_err = bad;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       tq_tick,
    input logic       bit_start,
    input logic       sample_pt,
    input logic [1:0] segment,
    input logic       cfg_err
);
    AST_SEG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        segment != 2'd3);                                               // R10
    AST_START_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |-> (tq_tick && segment == 2'd0));                    // R10
    AST_SAMPLE_ON_PH1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |-> (tq_tick && segment == 2'd1));                    // R7
    AST_PH2_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |=> (segment == 2'd2));                               // R7
    AST_QUIET_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!tq_tick && !bit_start && !sample_pt && segment == 2'd0)); // R6
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> $stable(cfg_err));                // R8
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tq_tick   (tq_tick),
    .bit_start (bit_start),
    .sample_pt (sample_pt),
    .segment   (segment),
    .cfg_err   (cfg_err)
);

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/1ps
module sim_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [5:0] prescale = '0;
    logic [3:0] seg1_len = 4'd4;
    logic [2:0] seg2_len = 3'd3;
    logic       tq_tick, bit_start, sample_pt, cfg_err;
    logic [1:0] segment;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    can_bit_timer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
        .seg1_len(seg1_len), .seg2_len(seg2_len), .tq_tick(tq_tick),
        .bit_start(bit_start), .sample_pt(sample_pt), .segment(segment),
        .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model_bad(input int p, input int a, input int b);
        if (a < 3 || b == 0) return 1'b1;
        if (b == 1) return (a < 4) || (p == 0);
        return !(a > b);
    endfunction

    task automatic load(input int p, input int a, input int b);
        @(negedge clk);
        enable   = 1'b0;
        prescale = 6'(p);
        seg1_len = 4'(a);
        seg2_len = 3'(b);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R6 reset tick", int'(tq_tick), 0);
        check("R6 reset bit_start", int'(bit_start), 0);
        check("R10 reset segment", int'(segment), 0);
    endtask

    // R1 R2 R7 R9 R10: timing of the first bits for one legal setting
    task automatic t_timing(input int p, input int a, input int b);
        int q, n, ticks;
        q = 2 * (p + 1);
        load(p, a, b);
        check("R3 legal setting flag", int'(cfg_err), 0);
        enable = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!bit_start && n < 5000);
        check("R9 enable to first bit_start", n, q - 1);
        check("R10 segment at bit_start", int'(segment), 0);
        n = 0;
        ticks = 1;
        do begin
            @(negedge clk); n++;
            if (tq_tick) ticks++;
            if (tq_tick && n != (ticks - 1) * q) check("R1 tick spacing", n, (ticks - 1) * q);
        end while (!sample_pt && n < 5000);
        check("R7 sample point offset", n, (a + 1) * q);
        check("R10 segment at sample", int'(segment), 1);
        @(negedge clk); n++;
        check("R7 sample one cycle", int'(sample_pt), 0);
        check("R7 segment after sample", int'(segment), 2);
        do begin
            if (tq_tick) ticks++;
            @(negedge clk); n++;
        end while (!bit_start && n < 5000);
        check("R2 bit length cycles", n, q * (3 + a + b));
        check("R2 quanta per bit", ticks, 3 + a + b);
        enable = 1'b0;
    endtask

    // R3 R4 R5: full legality matrix for two prescaler values
    task automatic t_matrix();
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 8; b++) begin
                    load(p * 5, a, b);
                    if (b == 1) check("R5 short seg2 rule", int'(cfg_err), int'(model_bad(p * 5, a, b)));
                    else if (a < 3 || b == 0) check("R3 minimum codes", int'(cfg_err), 1);
                    else check("R4 seg1 above seg2", int'(cfg_err), int'(model_bad(p * 5, a, b)));
                end
            end
        end
    endtask

    // R6: illegal setting with enable high gives no pulses
    task automatic t_quiet();
        int pulses;
        load(0, 4, 1);
        check("R5 zero prescaler short seg2", int'(cfg_err), 1);
        enable = 1'b1;
        pulses = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tq_tick || bit_start || sample_pt || segment != 2'd0) pulses++;
        end
        check("R6 no activity on error", pulses, 0);
        enable = 1'b0;
    endtask

    // R8: inputs changed during a run are ignored
    task automatic t_frozen();
        int n;
        load(1, 5, 2);
        enable = 1'b1;
        do @(negedge clk); while (!bit_start);
        prescale = 6'd0;
        seg1_len = 4'd0;
        seg2_len = 3'd0;
        n = 0;
        do begin
            @(negedge clk); n++;
            if (cfg_err) check("R8 flag frozen", 1, 0);
        end while (!bit_start && n < 5000);
        check("R8 period unchanged", n, 4 * (3 + 5 + 2));
        check("R8 flag after changes", int'(cfg_err), 0);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 capture when disabled", int'(cfg_err), 1);
    endtask

    // R11: reference 1 Mbit/s at 20 MHz -> 20 clocks per bit
    task automatic t_ref();
        int n;
        load(0, 4, 3);
        enable = 1'b1;
        do @(negedge clk); while (!bit_start);
        for (int k = 0; k < 3; k++) begin
            n = 0;
            do begin @(negedge clk); n++; end while (!bit_start && n < 100);
            check("R11 reference bit period", n, 20);
        end
        enable = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_timing(0, 4, 3);
        t_timing(2, 7, 4);
        t_timing(3, 15, 7);
        t_timing(1, 3, 2);
        t_matrix();
        t_quiet();
        t_frozen();
        t_ref();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule